// File: doc/BRIEF.md
# Narrow-Device Byte Lane Sequencer

This block sits between a 32-bit little-endian host port and a 32-bit local data bus. The device on the local bus may be 32, 16 or 8 bits wide. Each host word turns into one, two or four beats on the local bus. For narrow devices the bytes go onto an upper or a lower group of byte lanes. A per-beat lane-enable vector marks which lanes carry data. In big-endian mode the lower-numbered byte of each pair goes on the more significant lane. The same lane mapping runs in reverse for reads: the block collects the narrow beats and returns one 32-bit word to the host.

Each access carries a class code. Each class has its own stored endian bit. For configuration accesses, an override pin can replace the stored bit while the access is being accepted. The width, the lane group and the endian choice are all latched when the host word is accepted. Both sides use valid/ready handshakes.

Top module: `lane_seq`

## Requirements
- R1: After reset, `h_ready_o` is 1, and `l_valid_o` and `r_valid_o` are both 0.
- R2: When the width code is 0 (32-bit), the word takes one beat with `l_be_o`=4'b1111. In little-endian mode the word is unchanged. In big-endian mode host byte 0 (bits [7:0]) goes on [31:24], byte 1 on [23:16], byte 2 on [15:8] and byte 3 on [7:0]. Width code 3 behaves like code 0.
- R3: When the width code is 1 (16-bit) and mode is big-endian, the block emits two beats. With the upper group, beat k drives byte 2k on [31:24] and byte 2k+1 on [23:16]. With the lower group, beat k drives them on [15:8] and [7:0].
- R4: When the width code is 2 (8-bit), the block emits four beats. Beat k drives byte k on [31:24] when `cfg_upper_i`=1, or on [7:0] when `cfg_upper_i`=0. This holds in either endian mode.
- R5: When the width code is 1 and mode is little-endian, beat k drives byte 2k on the less significant lane of the selected group and byte 2k+1 on the more significant lane.
- R6: The endian mode comes from `cfg_big_i[c]` for class code c in 0..5 (0 configuration, 1 space 0, 2 space 1, 3 expansion ROM, 4 DMA channel 0, 5 DMA channel 1). A value of 1 means big-endian. Class codes 6 and 7 are little-endian.
- R7: For class 0 with `ovr_en_i`=1, `ovr_big_i` sets the mode and `cfg_big_i[0]` is ignored. The override pins have no effect on any other class.
- R8: During each beat, `l_be_o` has a 1 exactly on the byte lanes in use and every other lane of `l_wdata_o` is 0. During read beats, `l_wdata_o` is all zero.
- R9: A beat stays on the bus, unchanged, until `l_ready_i` is high at a clock edge. The next beat appears in the cycle after that edge.
- R10: `h_ready_o` is low from the cycle after a word is accepted until the last beat of a write completes, or until a read result is taken. A waiting `h_valid_i` is not accepted in that time.
- R11: A read collects the lanes of each beat using the R2–R5 mapping in reverse and ignores the unused lanes. `r_valid_o` rises in the cycle after the last beat and holds `r_data_o` stable until `r_ready_i` is high.
- R12: Changing width, lane group, endian settings or override pins after a word has been accepted has no effect on the beats of that word. `l_write_o` stays stable throughout a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_big_i | input | 6 | Stored endian bit per access class (1 = big-endian) |
| cfg_width_i | input | 2 | Device width code: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit |
| cfg_upper_i | input | 1 | Lane group for narrow devices: 1 = upper, 0 = lower |
| ovr_en_i | input | 1 | Enables the override pin for class 0 |
| ovr_big_i | input | 1 | Endian mode applied to class 0 when the override is enabled |
| h_valid_i | input | 1 | Host request valid |
| h_ready_o | output | 1 | Block can accept a host request |
| h_write_i | input | 1 | 1 = write, 0 = read |
| h_class_i | input | 3 | Access class code |
| h_wdata_i | input | 32 | Host write word, little-endian |
| r_valid_o | output | 1 | Read result valid |
| r_ready_i | input | 1 | Host takes the read result |
| r_data_o | output | 32 | Collected read word |
| l_valid_o | output | 1 | Local beat valid |
| l_ready_i | input | 1 | Local side completes the beat |
| l_write_o | output | 1 | Direction of the current word |
| l_wdata_o | output | 32 | Local write data for the beat |
| l_be_o | output | 4 | Byte lanes in use during the beat |
| l_rdata_i | input | 32 | Local read data for the beat |

## Verification
The assertions check the following on every cycle:
- a stalled beat holds its data and lane enables;
- the lane-enable vector takes one of its five legal shapes;
- disabled lanes and read-beat data are zero;
- host acceptance never overlaps a burst or a pending result;
- a pending read result stays stable.

Only the bench scenarios can show the rest:
- which byte lands on which lane in each width, group and endian mode;
- the per-class endian choice and the override pin;
- the reverse collection on reads;
- that settings changed in the middle of a burst have no effect.

The bench checks these by comparing every cycle against a queue-based reference model, with stalls from a pseudo-random ready pattern.

// File: rtl/lane_seq.sv
module lane_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  cfg_big_i,
  input  logic [1:0]  cfg_width_i,
  input  logic        cfg_upper_i,
  input  logic        ovr_en_i,
  input  logic        ovr_big_i,
  input  logic        h_valid_i,
  output logic        h_ready_o,
  input  logic        h_write_i,
  input  logic [2:0]  h_class_i,
  input  logic [31:0] h_wdata_i,
  output logic        r_valid_o,
  input  logic        r_ready_i,
  output logic [31:0] r_data_o,
  output logic        l_valid_o,
  input  logic        l_ready_i,
  output logic        l_write_o,
  output logic [31:0] l_wdata_o,
  output logic [3:0]  l_be_o,
  input  logic [31:0] l_rdata_i
);
  localparam logic [1:0] W16 = 2'd1;
  localparam logic [1:0] W8  = 2'd2;

  logic        busy, rdone, wr, big, upper;
  logic [1:0]  wid, beat, last;
  logic [31:0] word, rbuf, out;
  logic [15:0] pair_out, pair_in;
  logic [7:0]  lo_b, hi_b, one_b;
  logic        sel_big;

  wire accept = h_valid_i && h_ready_o;
  wire fire   = l_valid_o && l_ready_i;
  wire take   = r_valid_o && r_ready_i;

  assign h_ready_o = !busy;
  assign l_valid_o = busy && !rdone;
  assign r_valid_o = rdone;
  assign r_data_o  = rbuf;
  assign l_write_o = wr;
  assign last      = (wid == W16) ? 2'd1 : (wid == W8) ? 2'd3 : 2'd0;

  always_comb begin
    case (h_class_i)
      3'd0:    sel_big = ovr_en_i ? ovr_big_i : cfg_big_i[0];
      3'd1:    sel_big = cfg_big_i[1];
      3'd2:    sel_big = cfg_big_i[2];
      3'd3:    sel_big = cfg_big_i[3];
      3'd4:    sel_big = cfg_big_i[4];
      3'd5:    sel_big = cfg_big_i[5];
      default: sel_big = 1'b0;
    endcase
  end

  assign lo_b     = word[{beat[0], 4'b0000} +: 8];
  assign hi_b     = word[{beat[0], 4'b1000} +: 8];
  assign one_b    = word[{beat, 3'b000} +: 8];
  assign pair_out = big ? {lo_b, hi_b} : {hi_b, lo_b};
  assign pair_in  = upper ? l_rdata_i[31:16] : l_rdata_i[15:0];

  always_comb begin
    out    = '0;
    l_be_o = '0;
    case (wid)
      W16: begin
        if (upper) begin out[31:16] = pair_out; l_be_o = 4'b1100; end
        else       begin out[15:0]  = pair_out; l_be_o = 4'b0011; end
      end
      W8: begin
        if (upper) begin out[31:24] = one_b; l_be_o = 4'b1000; end
        else       begin out[7:0]   = one_b; l_be_o = 4'b0001; end
      end
      default: begin
        out    = big ? {word[7:0], word[15:8], word[23:16], word[31:24]} : word;
        l_be_o = 4'b1111;
      end
    endcase
  end

  assign l_wdata_o = wr ? out : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      rdone <= 1'b0;
      wr    <= 1'b0;
      big   <= 1'b0;
      upper <= 1'b0;
      wid   <= '0;
      beat  <= '0;
      word  <= '0;
      rbuf  <= '0;
    end else begin
      if (accept) begin
        busy  <= 1'b1;
        word  <= h_wdata_i;
        wr    <= h_write_i;
        big   <= sel_big;
        upper <= cfg_upper_i;
        wid   <= cfg_width_i;
        beat  <= '0;
        rbuf  <= '0;
      end
      if (fire) begin
        if (beat == last) begin
          beat <= '0;
          if (wr) busy  <= 1'b0;
          else    rdone <= 1'b1;
        end else begin
          beat <= beat + 2'd1;
        end
        if (!wr) begin
          case (wid)
            W16: begin
              rbuf[{beat[0], 4'b0000} +: 8] <= big ? pair_in[15:8] : pair_in[7:0];
              rbuf[{beat[0], 4'b1000} +: 8] <= big ? pair_in[7:0]  : pair_in[15:8];
            end
            W8: rbuf[{beat, 3'b000} +: 8] <= upper ? l_rdata_i[31:24] : l_rdata_i[7:0];
            default: rbuf <= big ? {l_rdata_i[7:0], l_rdata_i[15:8], l_rdata_i[23:16], l_rdata_i[31:24]}
                                 : l_rdata_i;
          endcase
        end
      end
      if (take) begin
        busy  <= 1'b0;
        rdone <= 1'b0;
      end
    end
  end
endmodule

module lane_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        h_ready_o,
  input logic        r_valid_o,
  input logic        r_ready_i,
  input logic [31:0] r_data_o,
  input logic        l_valid_o,
  input logic        l_ready_i,
  input logic        l_write_o,
  input logic [31:0] l_wdata_o,
  input logic [3:0]  l_be_o
);
  logic [31:0] lane_mask;
  assign lane_mask = {{8{l_be_o[3]}}, {8{l_be_o[2]}}, {8{l_be_o[1]}}, {8{l_be_o[0]}}};

  p_beat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    l_valid_o && !l_ready_i |=> l_valid_o && $stable(l_wdata_o) && $stable(l_be_o));

  p_be_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    l_valid_o |-> (l_be_o == 4'b1111 || l_be_o == 4'b1100 || l_be_o == 4'b0011 ||
                   l_be_o == 4'b1000 || l_be_o == 4'b0001));

  p_idle_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    l_valid_o |-> (l_wdata_o & ~lane_mask) == 32'h0);

  p_read_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    l_valid_o && !l_write_o |-> l_wdata_o == 32'h0);

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready_o |-> !l_valid_o && !r_valid_o);

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid_o && !r_ready_i |=> r_valid_o && $stable(r_data_o));

  p_dir_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    l_valid_o && !l_ready_i |=> $stable(l_write_o));
endmodule

bind lane_seq lane_seq_chk u_chk (.*);

// File: tb/lane_seq_test.sv
`timescale 1ns/1ps
module lane_seq_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cfg_upper_i, ovr_en_i, ovr_big_i;
  logic [5:0]  cfg_big_i;
  logic [1:0]  cfg_width_i;
  logic        h_valid_i, h_ready_o, h_write_i;
  logic [2:0]  h_class_i;
  logic [31:0] h_wdata_i, r_data_o, l_wdata_o, l_rdata_i;
  logic        r_valid_o, r_ready_i, l_valid_o, l_ready_i, l_write_o;
  logic [3:0]  l_be_o;

  lane_seq uut (.*);

  typedef struct packed { logic [31:0] d; logic [3:0] be; logic [31:0] dev; } beat_t;
  beat_t q[$];
  int errs = 0, checks = 0, r_wait = 0;
  string tag = "R1";
  bit exp_busy, exp_rpend, fire_h, fire_l, fire_r, pend, cur_write, p_write, stall;
  logic [31:0] exp_rword, p_data;
  logic [2:0]  p_cls;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic bit ref_big(logic [2:0] c);
    if (c == 3'd0 && ovr_en_i) return ovr_big_i;
    if (c < 3'd6) return cfg_big_i[c];
    return 1'b0;
  endfunction

  function automatic void build();
    int bpb = (cfg_width_i == 2'd1) ? 2 : (cfg_width_i == 2'd2) ? 1 : 4;
    bit bg = ref_big(p_cls);
    for (int k = 0; k < 4 / bpb; k++) begin
      beat_t b;
      b.d = '0; b.be = '0; b.dev = 32'hA5C3_5A3C;
      for (int j = 0; j < bpb; j++) begin
        int i = k * bpb + j;
        int lane;
        if (bpb == 4)      lane = bg ? 3 - j : j;
        else if (bpb == 2) lane = (cfg_upper_i ? 2 : 0) + (bg ? 1 - j : j);
        else               lane = cfg_upper_i ? 3 : 0;
        b.d[lane*8 +: 8]   = p_data[i*8 +: 8];
        b.dev[lane*8 +: 8] = p_data[i*8 +: 8];
        b.be[lane] = 1'b1;
      end
      if (!p_write) b.d = '0;
      q.push_back(b);
    end
    exp_rword = p_data;
  endfunction

  task automatic tick();
    @(negedge clk);
    if (fire_l) begin
      void'(q.pop_front());
      if (q.size() == 0) begin
        if (cur_write) exp_busy = 1'b0; else exp_rpend = 1'b1;
      end
    end
    if (fire_r) begin exp_rpend = 1'b0; exp_busy = 1'b0; end
    chk("R10 h_ready", {31'd0, h_ready_o}, {31'd0, !exp_busy});
    chk("R9 l_valid", {31'd0, l_valid_o}, {31'd0, q.size() != 0});
    chk("R11 r_valid", {31'd0, r_valid_o}, {31'd0, exp_rpend});
    if (r_valid_o && exp_rpend) chk({tag, " R11 r_data"}, r_data_o, exp_rword);
    if (l_valid_o && q.size() != 0) begin
      chk({tag, " beat data"}, l_wdata_o, q[0].d);
      chk({tag, " R8 lane enables"}, {28'd0, l_be_o}, {28'd0, q[0].be});
      chk("R12 direction", {31'd0, l_write_o}, {31'd0, cur_write});
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    l_ready_i = stall ? lfsr[0] : 1'b1;
    l_rdata_i = (q.size() != 0) ? q[0].dev : 32'hDEAD_BEEF;
    r_ready_i = 1'b0;
    if (r_valid_o) begin
      if (r_wait > 0) r_wait--; else r_ready_i = 1'b1;
    end
    fire_l = l_valid_o && l_ready_i;
    fire_r = r_valid_o && r_ready_i;
    fire_h = 1'b0;
    if (pend) begin
      h_valid_i = 1'b1; h_write_i = p_write; h_class_i = p_cls; h_wdata_i = p_data;
      if (h_ready_o) begin
        fire_h = 1'b1; pend = 1'b0; cur_write = p_write; exp_busy = 1'b1;
        build();
      end
    end else begin
      h_valid_i = 1'b0;
    end
  endtask

  task automatic post(bit w, logic [2:0] c, logic [31:0] d, int rw);
    p_write = w; p_cls = c; p_data = d; pend = 1'b1; r_wait = rw;
    do tick(); while (pend);
  endtask

  task automatic finish_word();
    tick();
    while (exp_busy) tick();
  endtask

  task automatic send(bit w, logic [2:0] c, logic [31:0] d, int rw);
    post(w, c, d, rw);
    finish_word();
  endtask

  initial begin
    #1_500_000;
    errs++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_big_i = '0; cfg_width_i = '0; cfg_upper_i = 1'b0;
    ovr_en_i = 1'b0; ovr_big_i = 1'b0; h_valid_i = 1'b0; h_write_i = 1'b0;
    h_class_i = '0; h_wdata_i = '0; r_ready_i = 1'b0; l_ready_i = 1'b0; l_rdata_i = '0;
    stall = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 h_ready after reset", {31'd0, h_ready_o}, 32'd1);
    chk("R1 l_valid after reset", {31'd0, l_valid_o}, 32'd0);
    chk("R1 r_valid after reset", {31'd0, r_valid_o}, 32'd0);

    tag = "R2";
    send(1, 3'd1, 32'h4433_2211, 0);
    cfg_big_i = 6'b000010;
    send(1, 3'd1, 32'h4433_2211, 0);
    cfg_width_i = 2'd3;
    send(1, 3'd1, 32'h8877_6655, 0);

    tag = "R3";
    cfg_width_i = 2'd1;
    for (int u = 0; u < 2; u++) begin
      cfg_upper_i = u[0];
      send(1, 3'd1, 32'hD4C3_B2A1, 0);
    end

    tag = "R5";
    cfg_big_i = 6'b000000;
    for (int u = 0; u < 2; u++) begin
      cfg_upper_i = u[0];
      send(1, 3'd1, 32'h1234_5678, 0);
    end

    tag = "R4";
    cfg_width_i = 2'd2;
    for (int e = 0; e < 2; e++) begin
      cfg_big_i = e[0] ? 6'b111111 : 6'b000000;
      for (int u = 0; u < 2; u++) begin
        cfg_upper_i = u[0];
        send(1, 3'd4, 32'hCAFE_F00D, 0);
      end
    end

    tag = "R6";
    cfg_width_i = 2'd1; cfg_upper_i = 1'b0; cfg_big_i = 6'b010110;
    for (int c = 0; c < 8; c++) send(1, c[2:0], 32'h0403_0201 + c, 0);
    cfg_big_i = 6'b101001;
    for (int c = 0; c < 8; c++) send(1, c[2:0], 32'hF1E2_D3C4 ^ c, 0);

    tag = "R7";
    cfg_big_i = 6'b000000; ovr_en_i = 1'b1; ovr_big_i = 1'b1;
    send(1, 3'd0, 32'hAABB_CCDD, 0);
    cfg_big_i = 6'b000001; ovr_big_i = 1'b0;
    send(1, 3'd0, 32'hAABB_CCDD, 0);
    ovr_big_i = 1'b1;
    send(1, 3'd2, 32'h1122_3344, 0);
    ovr_en_i = 1'b0;
    send(1, 3'd0, 32'h5566_7788, 0);

    tag = "R9";
    stall = 1'b1;
    cfg_width_i = 2'd2; cfg_upper_i = 1'b1;
    for (int n = 0; n < 6; n++) send(1, 3'd3, 32'h9E37_79B9 * (n + 1), 0);

    tag = "R11";
    for (int m = 0; m < 6; m++) begin
      cfg_width_i = (m % 3 == 0) ? 2'd0 : (m % 3 == 1) ? 2'd1 : 2'd2;
      cfg_upper_i = m[0];
      cfg_big_i = m[1] ? 6'b111111 : 6'b000000;
      send(0, 3'd5, 32'h0BAD_F00D + m * 32'h0101_0101, m);
    end

    tag = "R10";
    stall = 1'b0;
    cfg_width_i = 2'd2;
    post(1, 3'd1, 32'h1357_9BDF, 0);
    post(1, 3'd1, 32'h2468_ACE0, 0);
    finish_word();
    post(0, 3'd1, 32'h7654_3210, 4);
    post(1, 3'd1, 32'h0F1E_2D3C, 0);
    finish_word();

    tag = "R12";
    stall = 1'b1;
    cfg_width_i = 2'd1; cfg_upper_i = 1'b1; cfg_big_i = 6'b000010;
    post(1, 3'd1, 32'hA1B2_C3D4, 0);
    tick();
    cfg_width_i = 2'd2; cfg_upper_i = 1'b0; cfg_big_i = 6'b000000;
    while (exp_busy) tick();
    cfg_width_i = 2'd2; cfg_upper_i = 1'b0; cfg_big_i = 6'b111111;
    post(0, 3'd4, 32'h5A6B_7C8D, 2);
    tick();
    cfg_width_i = 2'd0; cfg_upper_i = 1'b1; cfg_big_i = 6'b000000;
    while (exp_busy) tick();
    repeat (3) tick();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule